// File: doc/BRIEF.md
# Vector Loop State Register

This block keeps the 64-bit loop state that a scalar core's vector extension carries beside its program counter. The word holds the largest allowed vector length, the active vector length, a source and a destination element counter, the sub-vector length code and a sub-vector counter. It also holds five remap selectors with their enable bits, a parallelism hint, a remap persistence bit and a vertical-first flag. The core reads and writes the word through a special-purpose-register port. A separate register select reaches the save copy that trap handling uses.

As element operations complete, the block advances the counters. The sub-vector counter is innermost. When it wraps, the two element counters step together. When the last element wraps, all counters return to zero and a one-cycle completion pulse is raised. With the vertical-first flag set, completions are ignored and only an explicit step request advances the counters.

On trap entry the whole word is copied into the save register in the same clock edge at which the core saves its PC. On trap return the word is reloaded from the save register in the edge at which the PC is restored.

Top module: `vec_loop_state`

## Requirements
- R1: While `rst` is high at a clock edge, the state word and the save word become zero, and `loop_done` and `subvl_illegal` become low.
- R2: Fields are numbered with bit 0 as the most significant (LSB-0 index = 63 - n). maxvl is 0:6 ([63:57]), vl is 7:13 ([56:50]), srcstep is 14:20 ([49:43]), dststep is 21:27 ([42:36]), the sub-vector length code is 28:29 ([35:34]), and svstep is 30:31 ([33:32]). The remap selectors are at 32:33 through 40:41 ([31:22]), the enables are 42:46 ([21:17]), the hint is 55:61 ([8:2]), persistence is 62 ([1]) and vertical-first is 63 ([0]). A write with `spr_we` high and `spr_sel` = 0 stores the word, and `spr_rdata` shows the selected register in the same cycle.
- R3: The reserved bits 47:54 ([16:9]) ignore written values and always read as zero, for both the state and the save register.
- R4: A written vl greater than the written maxvl is stored as maxvl.
- R5: With vertical-first clear, each cycle with `elem_done` high advances svstep. When svstep reaches the length code (SUBVL-1), it wraps to 0 and srcstep and dststep each increment.
- R6: When svstep wraps while srcstep is at vl-1 or higher, srcstep, dststep and svstep all become 0, and `loop_done` is high for exactly the following cycle. A vl of 0 never advances.
- R7: With vertical-first set, `elem_done` has no effect, and the counters advance only on a cycle with `step_req` high.
- R8: On a `trap_enter` cycle, the save register takes the complete state word from before that edge, and the state word is held.
- R9: `trap_enter` wins over every other request in its cycle (step, completion, register write, length load, trap return). The value saved excludes any step.
- R10: A `trap_return` cycle without `trap_enter` reloads the state word from the save register.
- R11: A `subvl_we` cycle with `subvl_len` in 1..4 stores `subvl_len`-1 in the length code (1 gives 0b00, 2 gives 0b01). A value of 0 or above 4 leaves the word unchanged and raises `subvl_illegal` for the following cycle.
- R12: The save register can be written (`spr_sel` = 1) and read through the register port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spr_we | input | 1 | Register write strobe |
| spr_sel | input | 1 | 0 selects the state word, 1 the save word |
| spr_wdata | input | 64 | Register write data |
| spr_rdata | output | 64 | Selected register contents |
| elem_done | input | 1 | An element operation completed |
| step_req | input | 1 | Explicit step request |
| trap_enter | input | 1 | Trap entry, PC saved this edge |
| trap_return | input | 1 | Trap return, PC restored this edge |
| subvl_we | input | 1 | Load a sub-vector length |
| subvl_len | input | 3 | Sub-vector length, legal 1 to 4 |
| state_o | output | 64 | Current state word |
| loop_done | output | 1 | Pulse after the last element wraps |
| subvl_illegal | output | 1 | Pulse after an illegal length load |

## Verification
Every register bit is on `state_o`. A wrong counter, a misplaced field or a lost save shows at the ports one cycle after the edge that caused it. A carry from svstep into the element counters that happens early or late appears as a wrong srcstep on the very next completion. A misplaced wrap appears as a missing or extra `loop_done` pulse, visible one cycle after the final element. Trap faults appear in the save word on the cycle after entry, and in the state word one cycle after return.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int WORD_W  = 64;
  localparam int STEP_W  = 7;
  localparam int SUB_W   = 2;
  localparam int SEL_W   = 2;
  localparam int NSEL    = 5;
  localparam int HINT_W  = 7;
  localparam int RSVD_W  = 8;
  localparam int LEN_W   = 3;

  // Fields are defined with bit 0 as MSB; convert the last MSB-0 bit to an LSB-0 index.
  localparam int MAXVL_LO  = WORD_W - 1 - 6;
  localparam int VL_LO     = WORD_W - 1 - 13;
  localparam int SRC_LO    = WORD_W - 1 - 20;
  localparam int DST_LO    = WORD_W - 1 - 27;
  localparam int SUBVL_LO  = WORD_W - 1 - 29;
  localparam int SVSTEP_LO = WORD_W - 1 - 31;
  localparam int SEL0_LO   = WORD_W - 1 - 33;
  localparam int EN_LO     = WORD_W - 1 - 46;
  localparam int RSVD_LO   = WORD_W - 1 - 54;
  localparam int HINT_LO   = WORD_W - 1 - 61;
  localparam int PERSIST_B = WORD_W - 1 - 62;
  localparam int VFIRST_B  = WORD_W - 1 - 63;
endpackage

// File: rtl/vls_spr_clean.sv
module vls_spr_clean
  import vls_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] clean_o
);
  logic [STEP_W-1:0] maxvl_w, vl_w;

  always_comb begin
    maxvl_w = raw_i[MAXVL_LO +: STEP_W];
    vl_w    = raw_i[VL_LO +: STEP_W];
    clean_o = raw_i;
    clean_o[RSVD_LO +: RSVD_W] = '0;
    if (vl_w > maxvl_w) clean_o[VL_LO +: STEP_W] = maxvl_w;
  end
endmodule

// File: rtl/vls_step_unit.sv
module vls_step_unit
  import vls_pkg::*;
#(
  parameter int SW = STEP_W,
  parameter int BW = SUB_W
) (
  input  logic [SW-1:0] vl_i,
  input  logic [BW-1:0] subvl_i,
  input  logic [SW-1:0] src_i,
  input  logic [SW-1:0] dst_i,
  input  logic [BW-1:0] sv_i,
  output logic [SW-1:0] src_o,
  output logic [SW-1:0] dst_o,
  output logic [BW-1:0] sv_o,
  output logic          wrap_o
);
  localparam logic [SW-1:0] ONE = SW'(1);
  logic last_elem;

  always_comb begin
    last_elem = (src_i >= vl_i - ONE);
    src_o  = src_i;
    dst_o  = dst_i;
    sv_o   = sv_i;
    wrap_o = 1'b0;
    if (vl_i != '0) begin
      if (sv_i >= subvl_i) begin
        sv_o = '0;
        if (last_elem) begin
          src_o  = '0;
          dst_o  = '0;
          wrap_o = 1'b1;
        end else begin
          src_o = src_i + ONE;
          dst_o = dst_i + ONE;
        end
      end else begin
        sv_o = sv_i + BW'(1);
      end
    end
  end
endmodule

// File: rtl/vls_save_bank.sv
module vls_save_bank
  import vls_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture_i,
  input  logic [W-1:0] state_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] save_o
);
  always_ff @(posedge clk) begin
    if (rst)            save_o <= '0;
    else if (capture_i) save_o <= state_i;
    else if (wr_i)      save_o <= wdata_i;
  end

  // R8
  save_capture_chk: assert property (@(posedge clk) disable iff (rst)
    capture_i |=> save_o == $past(state_i));
  // R3
  save_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    save_o[RSVD_LO +: RSVD_W] == '0);
endmodule

// File: rtl/vec_loop_state.sv
module vec_loop_state
  import vls_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         spr_we,
  input  logic         spr_sel,
  input  logic [W-1:0] spr_wdata,
  output logic [W-1:0] spr_rdata,
  input  logic         elem_done,
  input  logic         step_req,
  input  logic         trap_enter,
  input  logic         trap_return,
  input  logic         subvl_we,
  input  logic [LEN_W-1:0] subvl_len,
  output logic [W-1:0] state_o,
  output logic         loop_done,
  output logic         subvl_illegal
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(1 << SUB_W);

  logic [W-1:0]      state_q, save_q, clean_w;
  logic [STEP_W-1:0] nsrc, ndst;
  logic [SUB_W-1:0]  nsv;
  logic              wrap_w, advance, len_ok, st_wr, sv_wr;
  logic [LEN_W-1:0]  len_m1;

  vls_spr_clean #(.W(W)) u_clean (.raw_i(spr_wdata), .clean_o(clean_w));

  vls_step_unit #(.SW(STEP_W), .BW(SUB_W)) u_step (
    .vl_i   (state_q[VL_LO +: STEP_W]),
    .subvl_i(state_q[SUBVL_LO +: SUB_W]),
    .src_i  (state_q[SRC_LO +: STEP_W]),
    .dst_i  (state_q[DST_LO +: STEP_W]),
    .sv_i   (state_q[SVSTEP_LO +: SUB_W]),
    .src_o  (nsrc),
    .dst_o  (ndst),
    .sv_o   (nsv),
    .wrap_o (wrap_w)
  );

  assign sv_wr = spr_we && spr_sel && !trap_enter;

  vls_save_bank #(.W(W)) u_save (
    .clk(clk), .rst(rst), .capture_i(trap_enter), .state_i(state_q),
    .wr_i(sv_wr), .wdata_i(clean_w), .save_o(save_q)
  );

  assign advance = state_q[VFIRST_B] ? step_req : elem_done;
  assign len_ok  = (subvl_len != '0) && (subvl_len <= MAX_LEN);
  assign len_m1  = subvl_len - LEN_W'(1);
  assign st_wr   = spr_we && !spr_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= '0;
      loop_done     <= 1'b0;
      subvl_illegal <= 1'b0;
    end else begin
      loop_done     <= 1'b0;
      subvl_illegal <= subvl_we && !len_ok;
      if (trap_enter) begin
        state_q <= state_q;
      end else if (trap_return) begin
        state_q <= save_q;
      end else if (st_wr) begin
        state_q <= clean_w;
      end else if (subvl_we) begin
        if (len_ok) state_q[SUBVL_LO +: SUB_W] <= len_m1[SUB_W-1:0];
      end else if (advance) begin
        state_q[SRC_LO +: STEP_W]    <= nsrc;
        state_q[DST_LO +: STEP_W]    <= ndst;
        state_q[SVSTEP_LO +: SUB_W]  <= nsv;
        loop_done                    <= wrap_w;
      end
    end
  end

  assign state_o   = state_q;
  assign spr_rdata = spr_sel ? save_q : state_q;

  // R4
  vl_le_maxvl_chk: assert property (@(posedge clk) disable iff (rst)
    state_q[VL_LO +: STEP_W] <= state_q[MAXVL_LO +: STEP_W]);
  // R3
  state_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    state_q[RSVD_LO +: RSVD_W] == '0);
  // R6
  done_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    loop_done |-> (state_q[SRC_LO +: STEP_W] == '0 && state_q[SVSTEP_LO +: SUB_W] == '0));
  // R7
  vfirst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q[VFIRST_B] && !step_req && !trap_enter && !trap_return && !st_wr && !subvl_we)
      |=> $stable(state_q));
  // R9
  trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    trap_enter |=> $stable(state_q));
  // R10
  trap_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_return && !trap_enter) |=> state_q == $past(save_q));
  // R11
  bad_len_chk: assert property (@(posedge clk) disable iff (rst)
    (subvl_we && (subvl_len == '0 || subvl_len > MAX_LEN)) |=> subvl_illegal);
endmodule

// File: tb/vec_loop_state_bench.sv
module vec_loop_state_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic        spr_we = 0, spr_sel = 0;
  logic [63:0] spr_wdata = '0;
  logic [63:0] spr_rdata, state_o;
  logic        elem_done = 0, step_req = 0, trap_enter = 0, trap_return = 0;
  logic        subvl_we = 0;
  logic [2:0]  subvl_len = '0;
  logic        loop_done, subvl_illegal;
  int          errors = 0, checks = 0;

  always #4 clk = ~clk;

  vec_loop_state u_vec_loop_state (
    .clk(clk), .rst(rst), .spr_we(spr_we), .spr_sel(spr_sel), .spr_wdata(spr_wdata),
    .spr_rdata(spr_rdata), .elem_done(elem_done), .step_req(step_req),
    .trap_enter(trap_enter), .trap_return(trap_return), .subvl_we(subvl_we),
    .subvl_len(subvl_len), .state_o(state_o), .loop_done(loop_done),
    .subvl_illegal(subvl_illegal)
  );

  function automatic logic [63:0] pack(int mx, int vl, int src, int dst, int sub, int sv,
                                       int vf);
    logic [63:0] w = '0;
    w[63:57] = 7'(mx); w[56:50] = 7'(vl); w[49:43] = 7'(src); w[42:36] = 7'(dst);
    w[35:34] = 2'(sub); w[33:32] = 2'(sv); w[0] = vf[0];
    return w;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic sel, logic [63:0] d);
    spr_we = 1; spr_sel = sel; spr_wdata = d;
    tick();
    spr_we = 0; spr_sel = 0;
  endtask

  task automatic t_reset();
    check("R1 state", state_o, '0);
    spr_sel = 1; #1; check("R1 save", spr_rdata, '0); spr_sel = 0;
    check("R1 done", {63'd0, loop_done}, 64'd0);
    check("R1 illegal", {63'd0, subvl_illegal}, 64'd0);
  endtask

  task automatic t_layout();
    logic [63:0] v = 64'hFE_3F_FFFF_FFFF_FFFF;
    v = pack(20, 9, 5, 6, 3, 2, 0);
    v[31:22] = 10'b10_01_11_00_10; v[21:17] = 5'b10110; v[8:2] = 7'd33; v[1] = 1;
    wr(0, v);
    check("R2 layout", state_o, v);
    check("R2 read", spr_rdata, v);
    wr(0, v | 64'h1FE00);
    check("R3 reserved", state_o, v);
  endtask

  task automatic t_clamp();
    wr(0, pack(5, 12, 0, 0, 0, 0, 0));
    check("R4 clamp", state_o, pack(5, 5, 0, 0, 0, 0, 0));
  endtask

  task automatic t_hstep();
    wr(0, pack(8, 3, 0, 0, 1, 0, 0));
    for (int i = 1; i <= 6; i++) begin
      int idx;
      elem_done = 1; tick(); elem_done = 0;
      idx = i % 6;
      check(i == 6 ? "R6 wrap" : "R5 step", state_o, pack(8, 3, idx/2, idx/2, 1, idx%2, 0));
      check("R6 done", {63'd0, loop_done}, {63'd0, i == 6});
    end
    tick();
    check("R6 done one cycle", {63'd0, loop_done}, 64'd0);
    wr(0, pack(8, 0, 0, 0, 0, 0, 0));
    elem_done = 1; tick(); elem_done = 0;
    check("R6 vl zero", state_o, pack(8, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_vfirst();
    wr(0, pack(8, 4, 1, 1, 0, 0, 1));
    elem_done = 1; tick(); tick(); elem_done = 0;
    check("R7 ignore done", state_o, pack(8, 4, 1, 1, 0, 0, 1));
    step_req = 1; tick(); step_req = 0;
    check("R7 step", state_o, pack(8, 4, 2, 2, 0, 0, 1));
  endtask

  task automatic t_trap();
    logic [63:0] s1 = pack(10, 6, 3, 3, 2, 1, 0);
    wr(0, s1);
    trap_enter = 1; elem_done = 1; trap_return = 1; tick();
    trap_enter = 0; elem_done = 0; trap_return = 0;
    check("R9 no step", state_o, s1);
    spr_sel = 1; #1; check("R8 saved", spr_rdata, s1); spr_sel = 0;
    wr(0, pack(2, 1, 0, 0, 0, 0, 1));
    trap_return = 1; tick(); trap_return = 0;
    check("R10 restore", state_o, s1);
    wr(1, pack(7, 7, 4, 4, 3, 3, 1) | 64'h1FE00);
    spr_sel = 1; #1;
    check("R12 save write", spr_rdata, pack(7, 7, 4, 4, 3, 3, 1));
    spr_sel = 0;
  endtask

  task automatic t_subvl();
    logic [63:0] b = pack(9, 4, 0, 0, 0, 0, 0);
    wr(0, b);
    subvl_we = 1; subvl_len = 3'd2; tick(); subvl_we = 0;
    check("R11 legal", state_o, pack(9, 4, 0, 0, 1, 0, 0));
    check("R11 no exc", {63'd0, subvl_illegal}, 64'd0);
    subvl_we = 1; subvl_len = 3'd5; tick(); subvl_we = 0;
    check("R11 illegal hold", state_o, pack(9, 4, 0, 0, 1, 0, 0));
    check("R11 exc", {63'd0, subvl_illegal}, 64'd1);
    subvl_we = 1; subvl_len = 3'd0; tick(); subvl_we = 0;
    check("R11 zero exc", {63'd0, subvl_illegal}, 64'd1);
    subvl_we = 1; subvl_len = 3'd4; tick(); subvl_we = 0;
    check("R11 len4", state_o, pack(9, 4, 0, 0, 3, 0, 0));
  endtask

  initial begin
    fork
      begin
        repeat (3) tick();
        rst = 0;
        t_reset();
        t_layout();
        t_clamp();
        t_hstep();
        t_vfirst();
        t_trap();
        t_subvl();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule